// File: doc/BRIEF.md
# Product-Term Macrocell with Output Polarity

This block is a single configurable logic cell of the kind that makes up a function block in a complex programmable logic device. Each input first passes through a two-input AND with its own gate bit. The gated inputs then feed five product terms. Each product term is the AND of the literals selected for it, and a literal is either the true form or the complement of a gated input. A single OR gate sums the five terms. An XOR stage then either passes that sum or inverts it, as one configuration bit selects.

Another configuration bit decides how the result leaves the cell. It either goes out combinationally or is captured in a dedicated flip-flop. That flip-flop has its own reset, set and clock-enable controls, and each of the three is switched in or out by its own configuration bit. The whole configuration is a static vector presented at a port.

Top module: `macrocell`

## Requirements
- R1: Input `i` reaches the product terms only when configuration bit `i` (bits `NUM_IN-1:0`) is 1. A gated-off input is seen as 0, so its true literal is false and its complement literal is true.
- R2: For term `p`, the true-literal enables sit at bits `NUM_IN + 2*NUM_IN*p` and upward (`NUM_IN` bits), and the complement enables sit in the next `NUM_IN` bits. The term is the AND of its enabled literals. A term with no literal enabled is 0.
- R3: The five terms are ORed together. The sum is then XORed with the invert bit, at offset 0 of the mode field that starts at `BASE = NUM_IN*(1+2*NUM_PT)`.
- R4: When the registered-mode bit (`BASE+1`) is 0, `macroOut` equals the polarity result with no clock latency.
- R5: When the registered-mode bit is 1, `macroOut` shows the polarity result captured at the last rising edge on which a load happened. Input changes between edges do not reach the output.
- R6: When the reset-use bit (`BASE+2`) is 1, a high `ffReset` clears the flip-flop at once, with no clock, and overrides set. When that bit is 0, `ffReset` is ignored.
- R7: When the set-use bit (`BASE+3`) is 1, a high `ffSet` makes the flip-flop 1 on the next rising edge. Set wins over load and ignores the clock enable. When that bit is 0, `ffSet` is ignored.
- R8: When the enable-use bit (`BASE+4`) is 1, the flip-flop loads only on edges where `ffClkEn` is 1 and otherwise holds. When that bit is 0, it loads on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Flip-flop clock |
| ffReset | input | 1 | Asynchronous active-high clear, used when enabled by configuration |
| ffSet | input | 1 | Synchronous set, used when enabled by configuration |
| ffClkEn | input | 1 | Clock enable, used when enabled by configuration |
| dataIn | input | NUM_IN | Logic inputs to the product-term plane |
| cfg | input | NUM_IN*(1+2*NUM_PT)+5 | Static configuration vector |
| macroOut | output | 1 | Macrocell output |

## Verification
The assertions take the configuration vector as static from one clock edge to the next. They also assume that `ffReset` is not raised between an edge that starts a load, set or hold window and the edge that closes it. Outside the reset checks, an active clear disables every property. The bench changes configuration and inputs only on falling edges. It raises reset only after the check that closes any such window, so every property compares state taken under one configuration.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;
  // Strobes from control to datapath flip-flop
  typedef struct packed {
    logic clear;   // asynchronous clear
    logic preset;  // synchronous set
    logic load;    // capture polarity result
  } ffStrobe_t;

  // Mode field offsets, relative to the end of the product-term plane
  localparam int OFS_INVERT = 0;
  localparam int OFS_REG    = 1;
  localparam int OFS_RSTEN  = 2;
  localparam int OFS_SETEN  = 3;
  localparam int OFS_CEEN   = 4;
  localparam int MODE_BITS  = 5;
endpackage

// File: rtl/macrocell_ctrl.sv
module macrocell_ctrl
  import macrocell_pkg::*;
(
  input  logic      ffReset,
  input  logic      ffSet,
  input  logic      ffClkEn,
  input  logic      rstEn,
  input  logic      setEn,
  input  logic      ceEn,
  output ffStrobe_t strobe
);
  always_comb begin
    strobe.clear  = rstEn & ffReset;
    strobe.preset = setEn & ffSet & ~strobe.clear;
    strobe.load   = ~ceEn | ffClkEn;
  end
endmodule

// File: rtl/macrocell_datapath.sv
module macrocell_datapath
  import macrocell_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int NUM_PT = 5
) (
  input  logic                     clk,
  input  logic [NUM_IN-1:0]        dataIn,
  input  logic [NUM_IN-1:0]        inGate,
  input  logic [NUM_PT*NUM_IN-1:0] litTrue,
  input  logic [NUM_PT*NUM_IN-1:0] litComp,
  input  logic                     invert,
  input  logic                     regMode,
  input  ffStrobe_t                strobe,
  output logic                     sopPol,
  output logic                     macroOut
);
  logic [NUM_IN-1:0] gatedIn;
  logic [NUM_PT-1:0] termVal;
  logic              sumOut;
  logic              ffQ;
  logic              clearA;

  // Each input enters the plane through a two-input AND with its gate bit
  assign gatedIn = dataIn & inGate;

  for (genvar p = 0; p < NUM_PT; p++) begin : g_term
    logic [NUM_IN-1:0] selT;
    logic [NUM_IN-1:0] selC;
    logic              anyLit;
    logic              allMatch;
    assign selT     = litTrue[p*NUM_IN +: NUM_IN];
    assign selC     = litComp[p*NUM_IN +: NUM_IN];
    assign anyLit   = |(selT | selC);
    assign allMatch = &((~selT | gatedIn) & (~selC | ~gatedIn));
    // An empty term contributes nothing to the sum
    assign termVal[p] = anyLit & allMatch;
  end

  assign sumOut = |termVal;
  assign sopPol = sumOut ^ invert;

  assign clearA = strobe.clear;

  always_ff @(posedge clk or posedge clearA) begin
    if (clearA)             ffQ <= 1'b0;
    else if (strobe.preset) ffQ <= 1'b1;
    else if (strobe.load)   ffQ <= sopPol;
  end

  assign macroOut = regMode ? ffQ : sopPol;
endmodule

// File: rtl/macrocell.sv
module macrocell
  import macrocell_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int NUM_PT = 5,
  localparam int BASE  = NUM_IN * (1 + 2 * NUM_PT),
  localparam int CFG_W = BASE + MODE_BITS
) (
  input  logic              clk,
  input  logic              ffReset,
  input  logic              ffSet,
  input  logic              ffClkEn,
  input  logic [NUM_IN-1:0] dataIn,
  input  logic [CFG_W-1:0]  cfg,
  output logic              macroOut
);
  logic [NUM_PT*NUM_IN-1:0] litTrue;
  logic [NUM_PT*NUM_IN-1:0] litComp;
  logic invert, regMode, rstEn, setEn, ceEn;
  logic sopPol;
  ffStrobe_t strobe;

  // Unpack the interleaved per-term literal fields
  for (genvar p = 0; p < NUM_PT; p++) begin : g_unpack
    assign litTrue[p*NUM_IN +: NUM_IN] = cfg[NUM_IN + 2*NUM_IN*p +: NUM_IN];
    assign litComp[p*NUM_IN +: NUM_IN] = cfg[NUM_IN + 2*NUM_IN*p + NUM_IN +: NUM_IN];
  end

  assign invert  = cfg[BASE + OFS_INVERT];
  assign regMode = cfg[BASE + OFS_REG];
  assign rstEn   = cfg[BASE + OFS_RSTEN];
  assign setEn   = cfg[BASE + OFS_SETEN];
  assign ceEn    = cfg[BASE + OFS_CEEN];

  macrocell_ctrl u_ctrl (
    .ffReset(ffReset), .ffSet(ffSet), .ffClkEn(ffClkEn),
    .rstEn(rstEn), .setEn(setEn), .ceEn(ceEn),
    .strobe(strobe)
  );

  macrocell_datapath #(.NUM_IN(NUM_IN), .NUM_PT(NUM_PT)) u_dp (
    .clk(clk), .dataIn(dataIn), .inGate(cfg[NUM_IN-1:0]),
    .litTrue(litTrue), .litComp(litComp),
    .invert(invert), .regMode(regMode), .strobe(strobe),
    .sopPol(sopPol), .macroOut(macroOut)
  );
endmodule

// File: rtl/macrocell_checker.sv
module macrocell_checker (
  input logic clk,
  input logic ffReset,
  input logic ffSet,
  input logic ffClkEn,
  input logic regMode,
  input logic rstEn,
  input logic setEn,
  input logic ceEn,
  input logic sopPol,
  input logic macroOut
);
  logic clearNow;
  assign clearNow = rstEn & ffReset;

  // R4: combinational mode follows the polarity stage
  assert_comb_follow_R4: assert property (@(posedge clk) disable iff (clearNow)
    !regMode |-> macroOut == sopPol);

  // R5: a load edge captures the polarity result
  assert_load_capture_R5: assert property (@(posedge clk) disable iff (clearNow)
    (regMode && (!ceEn || ffClkEn) && !(setEn && ffSet)) |=> macroOut == $past(sopPol));

  // R6: an active clear holds a registered output at 0
  assert_clear_zero_R6: assert property (@(posedge clk)
    (regMode && rstEn && ffReset) |-> !macroOut);

  // R7: set forces 1 on the next edge
  assert_set_one_R7: assert property (@(posedge clk) disable iff (clearNow)
    (regMode && setEn && ffSet) |=> macroOut);

  // R8: with the enable in use and low, the output holds
  assert_ce_hold_R8: assert property (@(posedge clk) disable iff (clearNow)
    (regMode && ceEn && !ffClkEn && !(setEn && ffSet)) |=> $stable(macroOut));
endmodule

bind macrocell macrocell_checker u_checker (
  .clk(clk), .ffReset(ffReset), .ffSet(ffSet), .ffClkEn(ffClkEn),
  .regMode(regMode), .rstEn(rstEn), .setEn(setEn), .ceEn(ceEn),
  .sopPol(sopPol), .macroOut(macroOut)
);

// File: tb/macrocell_bench.sv
module macrocell_bench;
  localparam int NI   = 4;
  localparam int NP   = 5;
  localparam int BASE = NI * (1 + 2 * NP);
  localparam int CW   = BASE + 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          ffReset = 1'b0, ffSet = 1'b0, ffClkEn = 1'b0;
  logic [NI-1:0] dataIn = '0;
  logic [CW-1:0] cfg = '0;
  logic          macroOut;

  macrocell #(.NUM_IN(NI), .NUM_PT(NP)) u_macrocell (
    .clk(clk), .ffReset(ffReset), .ffSet(ffSet), .ffClkEn(ffClkEn),
    .dataIn(dataIn), .cfg(cfg), .macroOut(macroOut)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b cfg=%h in=%h", req, act, exp, cfg, dataIn);
    end
  endtask

  // Reference: gated inputs, sum of non-empty products, then polarity
  function automatic logic refPol(input logic [CW-1:0] c, input logic [NI-1:0] d);
    logic [NI-1:0] g;
    logic s;
    g = d & c[NI-1:0];
    s = 1'b0;
    for (int p = 0; p < NP; p++) begin
      logic [NI-1:0] t, f;
      logic ok;
      t = c[NI + 2*NI*p +: NI];
      f = c[NI + 2*NI*p + NI +: NI];
      ok = (t != 0) || (f != 0);
      for (int i = 0; i < NI; i++) begin
        if (t[i] && !g[i]) ok = 1'b0;
        if (f[i] && g[i])  ok = 1'b0;
      end
      s = s | ok;
    end
    return s ^ c[BASE];
  endfunction

  function automatic logic [CW-1:0] randCfg();
    logic [CW-1:0] c;
    c = '0;
    c[NI-1:0] = NI'($urandom) | NI'($urandom);
    for (int p = 0; p < NP; p++) begin
      logic [NI-1:0] t, f;
      t = NI'($urandom) & NI'($urandom);
      f = NI'($urandom) & NI'($urandom) & ~t;
      c[NI + 2*NI*p +: NI] = t;
      c[NI + 2*NI*p + NI +: NI] = f;
    end
    return c;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] base;
    logic prev;

    // Reset state: registered mode with clear in use
    @(negedge clk);
    cfg[BASE+1] = 1'b1; cfg[BASE+2] = 1'b1; ffReset = 1'b1;
    #1 chk("R6 reset state", macroOut, 1'b0);
    @(negedge clk); ffReset = 1'b0; cfg = '0;

    // R1/R2/R3/R4: combinational sweeps, both polarities
    for (int k = 0; k < 60; k++) begin
      base = randCfg();
      for (int pol = 0; pol < 2; pol++) begin
        for (int d = 0; d < 16; d++) begin
          @(negedge clk);
          cfg = base; cfg[BASE] = pol[0]; dataIn = NI'(d);
          #1 chk("R4 comb sop", macroOut, refPol(cfg, dataIn));
        end
      end
    end

    // R2: all terms empty gives sum 0, inverted gives 1
    @(negedge clk); cfg = '0; cfg[NI-1:0] = '1; dataIn = 4'hF;
    #1 chk("R2 empty terms", macroOut, 1'b0);
    cfg[BASE] = 1'b1;
    #1 chk("R3 empty inverted", macroOut, 1'b1);

    // R1: gated-off input makes complement literal true
    @(negedge clk); cfg = '0; cfg[NI + NI + 2] = 1'b1; dataIn = 4'h4;
    #1 chk("R1 gated input complement", macroOut, 1'b1);
    cfg[2] = 1'b1;
    #1 chk("R1 open input complement", macroOut, 1'b0);

    // R5: registered sweeps, loads every edge
    for (int k = 0; k < 30; k++) begin
      base = randCfg();
      base[BASE] = k[0];
      base[BASE+1] = 1'b1;
      @(negedge clk); cfg = base; dataIn = '0;
      @(negedge clk);
      for (int d = 0; d < 16; d++) begin
        prev = refPol(cfg, dataIn);
        dataIn = NI'(d);
        #1 chk("R5 no comb path", macroOut, prev);
        @(negedge clk);
        chk("R5 registered sop", macroOut, refPol(cfg, dataIn));
      end
    end

    // R8: clock enable hold and load. Term0 = true literal of input 0
    @(negedge clk);
    cfg = '0; cfg[0] = 1'b1; cfg[NI] = 1'b1; cfg[BASE+1] = 1'b1; cfg[BASE+4] = 1'b1;
    ffClkEn = 1'b1; dataIn = 4'h1;
    @(negedge clk); chk("R8 load when enabled", macroOut, 1'b1);
    ffClkEn = 1'b0; dataIn = 4'h0;
    @(negedge clk); chk("R8 hold when disabled", macroOut, 1'b1);
    @(negedge clk); chk("R8 hold second edge", macroOut, 1'b1);
    ffClkEn = 1'b1;
    @(negedge clk); chk("R8 reload", macroOut, 1'b0);

    // R7: set ignores enable and wins over load
    ffClkEn = 1'b0; cfg[BASE+3] = 1'b1; ffSet = 1'b1;
    @(negedge clk); chk("R7 set with enable low", macroOut, 1'b1);
    ffSet = 1'b0; ffClkEn = 1'b1;
    @(negedge clk); chk("R7 after set reloads", macroOut, 1'b0);
    cfg[BASE+3] = 1'b0; ffSet = 1'b1;
    @(negedge clk); chk("R7 set ignored when unused", macroOut, 1'b0);
    ffSet = 1'b0;

    // R6: asynchronous clear, priority over set, ignored when unused
    dataIn = 4'h1;
    @(negedge clk); chk("R6 pre-clear load", macroOut, 1'b1);
    cfg[BASE+2] = 1'b1; cfg[BASE+3] = 1'b1;
    #1 ffReset = 1'b1;
    #1 chk("R6 clear without clock", macroOut, 1'b0);
    ffSet = 1'b1;
    @(negedge clk); chk("R6 clear beats set", macroOut, 1'b0);
    ffReset = 1'b0;
    @(negedge clk); chk("R7 set after clear", macroOut, 1'b1);
    ffSet = 1'b0; cfg[BASE+2] = 1'b0; ffClkEn = 1'b0;
    #1 ffReset = 1'b1;
    #1 chk("R6 clear ignored when unused", macroOut, 1'b1);
    @(negedge clk); chk("R6 ignored across edge", macroOut, 1'b1);
    ffReset = 1'b0;

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule